// File: doc/BRIEF.md
# Iterative Factorial Unit

This block computes the factorial of an unsigned operand with a controller state machine steering a small datapath. A pulse on the start input, seen while the unit is idle, captures the operand into a count register and sets an accumulator to one. While the count is greater than one, the unit makes one pass of the loop. The accumulator takes the product of itself and the count, and the count then drops by one. When the count reaches one or zero, the accumulator is shown on the result output and a completion flag rises.

The accumulator keeps only the low bits of every product, so results wrap modulo two to the width. Every pass of the loop costs two cycles: one to test the count and one to update both registers. The controller state is held in plain D flip-flops with a one-hot code, and the reset is synchronous.

Top module: `fact_unit`

## Requirements
- R1: After a synchronous reset, done is 0 and result is 0. The unit is idle and accepts the next start.
- R2: A start pulse seen while idle loads the count from n and sets the accumulator to 1.
- R3: While the count is greater than 1, each pass sets the accumulator to the low W bits of accumulator×count, then decrements the count.
- R4: When the loop ends, result holds the low W bits of n! and done is 1.
- R5: For n equal to 0 or 1 the loop body never runs, and result is 1.
- R6: Each pass of the loop takes exactly two cycles. done rises 2·max(n−1,0)+2 cycles after the cycle in which start is sampled.
- R7: done and result hold steady until the next start. A start received while busy is ignored and does not change the result.
- R8: A start received while done is high clears done and begins a new computation with the new n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin computation when idle or done |
| n | input | W | Operand |
| result | output | W | Factorial, low W bits |
| done | output | 1 | Result valid, held until next start |

## Verification
The bench builds the unit at its default width of 8 bits. At that width every operand from 0 to 255 can be swept in turn, and each result and each completion latency is compared with a factorial and a cycle count worked out in the bench. The sweep covers the zero and one operands and the wrap beyond 5!. It also covers the longest loop at 255, and it adds starts issued while the unit is busy and starts issued while done is high.

// File: rtl/fact_pkg.sv
package fact_pkg;
  typedef enum logic [3:0] {
    ST_IDLE = 4'b0001,
    ST_TEST = 4'b0010,
    ST_STEP = 4'b0100,
    ST_DONE = 4'b1000
  } fact_state_t;

  function automatic logic [15:0] mul_trunc16(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] full;
    full = a * b;
    return full[15:0];
  endfunction
endpackage

// File: rtl/fact_ctrl.sv
module fact_ctrl
  import fact_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cnt_gt1,
  output logic ld,
  output logic step,
  output logic fin,
  output logic done
);
  fact_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_TEST;
      ST_TEST: st_d = cnt_gt1 ? ST_STEP : ST_DONE;
      ST_STEP: st_d = ST_TEST;
      ST_DONE: if (start) st_d = ST_TEST;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign ld   = start && (st_q == ST_IDLE || st_q == ST_DONE);
  assign step = (st_q == ST_STEP);
  assign fin  = (st_q == ST_TEST) && !cnt_gt1;
  assign done = (st_q == ST_DONE);

  a_r6_onehot_state: assert property (@(posedge clk) disable iff (rst) $onehot(st_q));
  a_r3_step_follows_test: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TEST && cnt_gt1) |=> (st_q == ST_STEP));
  a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
endmodule

// File: rtl/fact_dpath.sv
module fact_dpath
  import fact_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         step,
  input  logic         fin,
  input  logic [W-1:0] n,
  output logic         cnt_gt1,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q, acc_q, res_q, prod;

  assign prod    = W'(mul_trunc16(16'(acc_q), 16'(cnt_q)));
  assign cnt_gt1 = cnt_q > ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      acc_q <= ONE;
      res_q <= '0;
    end else begin
      if (ld) begin
        cnt_q <= n;
        acc_q <= ONE;
      end else if (step) begin
        acc_q <= prod;
        cnt_q <= cnt_q - ONE;
      end
      if (fin) res_q <= acc_q;
    end
  end

  assign result = res_q;

  a_r3_count_decrements: assert property (@(posedge clk) disable iff (rst)
    (step && !ld) |=> (cnt_q == $past(cnt_q) - ONE));
  a_r2_load_sets_one: assert property (@(posedge clk) disable iff (rst)
    ld |=> (acc_q == ONE));
  a_r7_result_stable: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(res_q));
endmodule

// File: rtl/fact_unit.sv
module fact_unit
  import fact_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] n,
  output logic [W-1:0] result,
  output logic         done
);
  logic ld, step, fin, cnt_gt1;

  fact_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .cnt_gt1(cnt_gt1),
    .ld(ld), .step(step), .fin(fin), .done(done)
  );

  fact_dpath #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .ld(ld), .step(step), .fin(fin),
    .n(n), .cnt_gt1(cnt_gt1), .result(result)
  );

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (!done && result == '0));
  a_r4_done_after_fin: assert property (@(posedge clk) disable iff (rst) fin |=> done);
endmodule

// File: tb/sim_fact_unit.sv
module sim_fact_unit;
  localparam int W = 8;
  logic clk = 0, rst = 1, start = 0;
  logic [W-1:0] n = 0;
  logic [W-1:0] result;
  logic done;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fact_unit #(.W(W)) u0 (.clk(clk), .rst(rst), .start(start), .n(n), .result(result), .done(done));

  function automatic int exp_fact(input int v);
    int p = 1;
    for (int k = 2; k <= v; k++) p = (p * k) % 256;
    return p;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int v, input bit busy_poke);
    int lat = 0;
    int want = 2 * ((v > 1) ? v - 1 : 0) + 2;
    @(negedge clk); n = W'(v); start = 1;
    @(negedge clk); start = 0; n = 8'hAA; lat = 1;
    if (busy_poke && v > 2) begin
      start = 1; @(negedge clk); start = 0; lat++;
    end
    while (!done && lat < 1000) begin @(negedge clk); lat++; end
    chk("R4", result, exp_fact(v));
    if (v <= 1) chk("R5", result, 1);
    chk("R6", lat, want);
    if (busy_poke && v > 2) chk("R7 busy start ignored", result, exp_fact(v));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 result", result, 0);
    rst = 0;
    for (int v = 0; v < 256; v++) run(v, v % 7 == 3);
    repeat (5) @(negedge clk);
    chk("R7 hold done", done, 1);
    chk("R7 hold result", result, exp_fact(255));
    @(negedge clk); n = 8'd4; start = 1;
    @(negedge clk); start = 0;
    chk("R8 done cleared", done, 0);
    chk("R2 load", result, exp_fact(255));
    repeat (7) @(negedge clk);
    chk("R8 new result", result, 24);
    chk("R8 done", done, 1);
    rst = 1; @(negedge clk); rst = 0;
    chk("R1 after reset", done, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule